// File: doc/BRIEF.md
# Synthesizer Counter Programming Interface

This block is the control logic that sets up the divide values of an integer-N frequency synthesizer. It produces the reference divider value (6 bits), the main divider value (9 bits), the swallow counter value (4 bits) and the prescaler enable. It also produces a small set of control flags taken from an 8-bit auxiliary control register. Values can be loaded in three ways: as a 20-bit word shifted in one bit per serial clock, as three byte-wide writes on an 8-bit parallel bus, or straight from dedicated pins.

A 20-bit staging word (primary) can be copied into a second 20-bit word (secondary). A select input chooses which of the two drives the counters. This lets software prepare the next channel while the current one is in use, then hop by toggling the select. The auxiliary control register has its own serial shift stage and only changes on its capture event. Its flags take effect only while an active-low enable input is held low.

Every strobe and the serial clock come from slow off-chip sources. A two-stage synchronizer brings each one into the fast system clock domain, and an edge detector turns each edge into a single one-cycle event.

Top module: `synth_prog_ctrl`

## Requirements
- R1: Mode decode: `bus_direct`=1 selects direct mode whatever `bus_serial` is. `bus_direct`=0 with `bus_serial`=1 selects serial mode. Both 0 selects parallel mode. Serial clock edges have no effect in parallel mode.
- R2: In serial mode, with `ser_load` and `aux_wr` both low, each rising `ser_clk` shifts `ser_data` into the primary word at bit 0, so the first bit ends at bit 19. Field positions in the 20-bit word: [19:18]=ref[5:4], [17:16]=main[8:7], [15]=prescaler enable, [14:8]=main[6:0], [7:4]=ref[3:0], [3:0]=swallow.
- R3: Outside direct mode, `src_primary`=1 drives the outputs from the primary word and `src_primary`=0 drives them from the secondary word.
- R4: The secondary word takes a copy of the primary word on a rising `ser_load` in serial mode, or on a rising `hop_wr` in parallel mode. A rising `hop_wr` in serial mode is ignored.
- R5: In parallel mode, a rising `wr_main_lo` loads `pdata[7:0]` into primary [15:8]. A rising `wr_main_hi` loads `pdata[3:0]` into primary [19:16]. A rising `wr_ref_swl` loads `pdata[7:0]` into primary [7:0].
- R6: In serial mode, with `aux_wr` high and `ser_load` low, each rising `ser_clk` shifts `ser_data` into an 8-bit auxiliary shift stage, first bit ending at bit 7. The auxiliary register takes the stage on the falling edge of `aux_wr`, and not before.
- R7: In parallel mode, a rising `aux_wr` loads `pdata[7:0]` into the auxiliary register.
- R8: In direct mode, the outputs come from the `pin_*` inputs, with ref[5:4] and main[8:7] forced to 0.
- R9: Auxiliary flags are active high and take effect only while `aux_en_n`=0; otherwise all flag outputs are 0. Bit 3 = power down, bit 4 = immediate load, bit 5 = route modulus select to data-out, bit 6 = route raw prescaler to data-out, bit 7 = disable divider monitor outputs. Bits 0 to 2 are reserved and drive nothing.
- R10: If bits 5 and 6 are both set, only `dout_modsel` is asserted. Bit 5 has priority.
- R11: Each strobe or serial clock edge causes exactly one action, however long the level is held.
- R12: After reset the primary, secondary and auxiliary registers are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_direct | input | 1 | Selects direct mode when high |
| bus_serial | input | 1 | Serial (1) or parallel (0) when not direct |
| src_primary | input | 1 | Counter source: 1 primary, 0 secondary |
| aux_en_n | input | 1 | Active-low enable of auxiliary flags |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data |
| ser_load | input | 1 | Serial load strobe; also blocks shifting while high |
| aux_wr | input | 1 | Auxiliary write / serial target select |
| wr_main_lo | input | 1 | Parallel strobe for primary [15:8] |
| wr_main_hi | input | 1 | Parallel strobe for primary [19:16] |
| wr_ref_swl | input | 1 | Parallel strobe for primary [7:0] |
| hop_wr | input | 1 | Parallel primary-to-secondary copy strobe |
| pdata | input | 8 | Parallel data bus |
| pin_main | input | 7 | Direct-mode main divider value |
| pin_ref | input | 4 | Direct-mode reference divider value |
| pin_swl | input | 4 | Direct-mode swallow value |
| pin_pre_en | input | 1 | Direct-mode prescaler enable |
| ref_div | output | 6 | Reference divider value |
| main_div | output | 9 | Main divider value |
| swl_cnt | output | 4 | Swallow counter value |
| pre_en | output | 1 | Prescaler enable |
| pwr_down | output | 1 | Power-down flag |
| imm_load | output | 1 | Immediate counter load flag |
| dout_modsel | output | 1 | Route modulus select to data-out |
| dout_rawpre | output | 1 | Route raw prescaler output to data-out |
| mon_off | output | 1 | Disable divider monitor outputs |

## Verification
On every cycle, the assertions check the following. The secondary word changes only on a copy event, and then to the previous primary value. The auxiliary register holds between capture events. The primary word is left alone in direct mode. Direct-mode upper bits stay zero. Flags stay clear while disabled. At most one data-out route is active. A detected edge never repeats on the next cycle.

Only the bench's scenarios show the rest:
- the serial bit order and field placement;
- the byte mapping of the three parallel strobes;
- that auxiliary data is invisible until the falling edge of `aux_wr`;
- that `hop_wr` is ignored in serial mode;
- that long strobe levels act once.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W  = 20;
  localparam int AUX_W   = 8;
  localparam int AUX_LO  = 3;                 // lowest functional auxiliary bit
  localparam int FLAG_W  = AUX_W - AUX_LO;    // stored functional bits
  localparam int REF_W   = 6;
  localparam int MAIN_W  = 9;
  localparam int SWL_W   = 4;

  // auxiliary bit positions, relative to the full 8-bit register
  localparam int AUX_PD   = 3;
  localparam int AUX_LOAD = 4;
  localparam int AUX_MSEL = 5;
  localparam int AUX_RAW  = 6;
  localparam int AUX_OFF  = 7;

  // synchronized strobe indices
  localparam int S_SCK = 0;
  localparam int S_SLD = 1;
  localparam int S_AUX = 2;
  localparam int S_MLO = 3;
  localparam int S_MHI = 4;
  localparam int S_RSW = 5;
  localparam int S_HOP = 6;
  localparam int N_STB = 7;

  typedef enum logic [1:0] {MODE_PAR = 2'd0, MODE_SER = 2'd1, MODE_DIR = 2'd2} mode_e;

  typedef struct packed {
    logic [REF_W-1:0]  ref_v;
    logic [MAIN_W-1:0] main_v;
    logic [SWL_W-1:0]  swl_v;
    logic              pre;
  } cnt_t;

  function automatic mode_e decode_mode(input logic direct, input logic serial);
    if (direct)      return MODE_DIR;
    else if (serial) return MODE_SER;
    else             return MODE_PAR;
  endfunction

  function automatic cnt_t unpack_word(input logic [WORD_W-1:0] w);
    cnt_t c;
    c.ref_v  = {w[19:18], w[7:4]};
    c.main_v = {w[17:16], w[14:8]};
    c.swl_v  = w[3:0];
    c.pre    = w[15];
    return c;
  endfunction
endpackage

// File: rtl/synth_strobe_sync.sv
module synth_strobe_sync #(
  parameter int N      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] pipe [STAGES];
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      prev <= '0;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0)); // R11
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic [N_STB-1:0]  lvl,
  input  logic [N_STB-1:0]  rise,
  input  logic [N_STB-1:0]  fall,
  input  logic              sdi,
  input  logic [7:0]        din,
  output logic [WORD_W-1:0] prim,
  output logic [WORD_W-1:0] sec,
  output logic [FLAG_W-1:0] flags
);
  logic [AUX_W-1:0] aux_shift;
  logic is_ser, is_par;
  logic shift_prim, shift_aux, xfer, aux_cap;
  logic wr_lo, wr_hi, wr_rs;

  assign is_ser = (mode == MODE_SER);
  assign is_par = (mode == MODE_PAR);

  // named internal events
  assign shift_prim = is_ser & rise[S_SCK] & ~lvl[S_SLD] & ~lvl[S_AUX];
  assign shift_aux  = is_ser & rise[S_SCK] & ~lvl[S_SLD] &  lvl[S_AUX];
  assign xfer       = (is_ser & rise[S_SLD]) | (is_par & rise[S_HOP]);
  assign aux_cap    = (is_ser & fall[S_AUX]) | (is_par & rise[S_AUX]);
  assign wr_lo      = is_par & rise[S_MLO];
  assign wr_hi      = is_par & rise[S_MHI];
  assign wr_rs      = is_par & rise[S_RSW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim <= '0;
    end else if (shift_prim) begin
      prim <= {prim[WORD_W-2:0], sdi};
    end else begin
      if (wr_lo) prim[15:8]  <= din;
      if (wr_hi) prim[19:16] <= din[3:0];
      if (wr_rs) prim[7:0]   <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sec <= '0;
    else if (xfer) sec <= prim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         aux_shift <= '0;
    else if (shift_aux) aux_shift <= {aux_shift[AUX_W-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (aux_cap) flags <= is_ser ? aux_shift[AUX_W-1:AUX_LO] : din[AUX_W-1:AUX_LO];
  end

  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(sec)); // R4
  AST_SEC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (sec == $past(prim))); // R4
  AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_cap |=> $stable(flags)); // R6
  AST_PRIM_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DIR) |=> $stable(prim)); // R8
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_direct,
  input  logic              bus_serial,
  input  logic              src_primary,
  input  logic              aux_en_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_load,
  input  logic              aux_wr,
  input  logic              wr_main_lo,
  input  logic              wr_main_hi,
  input  logic              wr_ref_swl,
  input  logic              hop_wr,
  input  logic [7:0]        pdata,
  input  logic [6:0]        pin_main,
  input  logic [3:0]        pin_ref,
  input  logic [3:0]        pin_swl,
  input  logic              pin_pre_en,
  output logic [REF_W-1:0]  ref_div,
  output logic [MAIN_W-1:0] main_div,
  output logic [SWL_W-1:0]  swl_cnt,
  output logic              pre_en,
  output logic              pwr_down,
  output logic              imm_load,
  output logic              dout_modsel,
  output logic              dout_rawpre,
  output logic              mon_off
);
  logic [N_STB-1:0]  stb_raw, stb_lvl, stb_rise, stb_fall;
  logic [WORD_W-1:0] prim, sec;
  logic [FLAG_W-1:0] flags;
  mode_e             mode;
  cnt_t              word_cnt, pin_cnt, cnt;
  logic              flag_en;

  assign stb_raw[S_SCK] = ser_clk;
  assign stb_raw[S_SLD] = ser_load;
  assign stb_raw[S_AUX] = aux_wr;
  assign stb_raw[S_MLO] = wr_main_lo;
  assign stb_raw[S_MHI] = wr_main_hi;
  assign stb_raw[S_RSW] = wr_ref_swl;
  assign stb_raw[S_HOP] = hop_wr;

  synth_strobe_sync #(.N(N_STB), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(stb_raw),
    .lvl(stb_lvl), .rise(stb_rise), .fall(stb_fall)
  );

  assign mode = decode_mode(bus_direct, bus_serial);

  synth_prog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .lvl(stb_lvl), .rise(stb_rise), .fall(stb_fall),
    .sdi(ser_data), .din(pdata),
    .prim(prim), .sec(sec), .flags(flags)
  );

  always_comb begin
    word_cnt       = unpack_word(src_primary ? prim : sec);
    pin_cnt.ref_v  = {2'b00, pin_ref};
    pin_cnt.main_v = {2'b00, pin_main};
    pin_cnt.swl_v  = pin_swl;
    pin_cnt.pre    = pin_pre_en;
    cnt            = (mode == MODE_DIR) ? pin_cnt : word_cnt;
  end

  assign ref_div  = cnt.ref_v;
  assign main_div = cnt.main_v;
  assign swl_cnt  = cnt.swl_v;
  assign pre_en   = cnt.pre;

  assign flag_en     = ~aux_en_n;
  assign pwr_down    = flag_en & flags[AUX_PD   - AUX_LO];
  assign imm_load    = flag_en & flags[AUX_LOAD - AUX_LO];
  assign dout_modsel = flag_en & flags[AUX_MSEL - AUX_LO];
  assign dout_rawpre = flag_en & flags[AUX_RAW  - AUX_LO] & ~flags[AUX_MSEL - AUX_LO];
  assign mon_off     = flag_en & flags[AUX_OFF  - AUX_LO];

  AST_DIRECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_direct |-> (ref_div[5:4] == 2'b00 && main_div[8:7] == 2'b00)); // R8
  AST_FLAGS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en_n |-> ({pwr_down, imm_load, dout_modsel, dout_rawpre, mon_off} == '0)); // R9
  AST_DOUT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dout_modsel, dout_rawpre})); // R10
  AST_EDGE_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stb_rise & stb_fall) == '0) && ((stb_rise & ~stb_lvl) == '0)); // R11
endmodule

// File: tb/sim_synth_prog_ctrl.sv
module sim_synth_prog_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_direct = 0, bus_serial = 0, src_primary = 0, aux_en_n = 0;
  logic ser_clk = 0, ser_data = 0, ser_load = 0, aux_wr = 0;
  logic wr_main_lo = 0, wr_main_hi = 0, wr_ref_swl = 0, hop_wr = 0;
  logic [7:0] pdata = '0;
  logic [6:0] pin_main = '0;
  logic [3:0] pin_ref = '0, pin_swl = '0;
  logic pin_pre_en = 0;
  logic [5:0] ref_div; logic [8:0] main_div; logic [3:0] swl_cnt;
  logic pre_en, pwr_down, imm_load, dout_modsel, dout_rawpre, mon_off;

  int tests = 0, fails = 0;
  logic [19:0] m_prim = '0, m_sec = '0;
  logic [7:0]  m_aux = '0;

  always #2.5 clk = ~clk;

  synth_prog_ctrl u0 (.*);

  function automatic logic [24:0] expect_out(input logic dir, input logic fp, input logic en_n,
      input logic [19:0] p, input logic [19:0] s, input logic [7:0] e,
      input logic [6:0] dm, input logic [3:0] dr, input logic [3:0] da, input logic dp);
    logic [19:0] w;
    logic [5:0] r; logic [8:0] m; logic [3:0] a; logic pr;
    logic [4:0] f;
    w = fp ? p : s;
    if (dir) begin r = {2'b00, dr}; m = {2'b00, dm}; a = da; pr = dp; end
    else begin r = {w[19], w[18], w[7:4]}; m = {w[17], w[16], w[14:8]}; a = w[3:0]; pr = w[15]; end
    if (en_n) f = 5'b0;
    else f = {e[3], e[4], e[5], e[6] & ~e[5], e[7]};
    return {r, m, a, pr, f};
  endfunction

  task automatic check(input string tag);
    logic [24:0] act, exp;
    @(posedge clk); #1;
    act = {ref_div, main_div, swl_cnt, pre_en, pwr_down, imm_load, dout_modsel, dout_rawpre, mon_off};
    exp = expect_out(bus_direct, src_primary, aux_en_n, m_prim, m_sec, m_aux,
                     pin_main, pin_ref, pin_swl, pin_pre_en);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_stb(input int which, input logic v);
    case (which)
      0: wr_main_lo = v;
      1: wr_main_hi = v;
      2: wr_ref_swl = v;
      3: hop_wr = v;
      4: aux_wr = v;
      default: ser_load = v;
    endcase
  endtask

  task automatic pulse(input int which, input int hold);
    set_stb(which, 1'b1); idle(hold);
    set_stb(which, 1'b0); idle(5);
  endtask

  task automatic set_mode(input logic d, input logic s);
    idle(2); bus_direct = d; bus_serial = s; idle(2);
  endtask

  task automatic par_write(input int which, input logic [7:0] v);
    pdata = v; idle(2); pulse(which, 4);
    case (which)
      0: m_prim[15:8] = v;
      1: m_prim[19:16] = v[3:0];
      2: m_prim[7:0] = v;
      3: m_sec = m_prim;
      default: m_aux = {v[7:3], 3'b000};
    endcase
  endtask

  task automatic ser_bit(input logic b, input int hold);
    ser_data = b; idle(2);
    ser_clk = 1'b1; idle(hold);
    ser_clk = 1'b0; idle(4);
  endtask

  task automatic ser_word(input logic [19:0] w, input int hold);
    for (int i = 19; i >= 0; i--) ser_bit(w[i], hold);
    m_prim = w;
  endtask

  initial begin
    void'($urandom(32'd2718));
    idle(3); rst_n = 1'b1; idle(2);
    check("R12 reset secondary");
    src_primary = 1; check("R12 reset primary");

    // serial load, staging then copy
    set_mode(0, 1);
    ser_word(20'hA5C3E, 4);
    src_primary = 1; check("R2 serial word order");
    src_primary = 0; check("R3 secondary unchanged before copy");
    pulse(5, 4); m_sec = m_prim;
    check("R4 serial load copies to secondary");
    src_primary = 1; check("R3 primary select");

    // hop ignored in serial mode
    ser_word(20'h3F0A5, 4);
    pulse(3, 4);
    src_primary = 0; check("R4 hop ignored in serial");

    // long held serial clock acts once per edge
    ser_word(20'h81357, 15);
    src_primary = 1; check("R11 long held clock single shift");

    // auxiliary serial path
    aux_wr = 1; idle(4);
    for (int i = 7; i >= 0; i--) ser_bit(logic'((8'h2F >> i) & 1), 4);
    check("R6 aux invisible before falling edge");
    src_primary = 1; check("R6 primary untouched by aux shift");
    aux_wr = 0; idle(5); m_aux = 8'h28;
    check("R6 aux captured on falling edge");
    aux_en_n = 1; check("R9 flags gated by enable");
    aux_en_n = 0;

    // parallel mode
    set_mode(0, 0);
    par_write(0, 8'hB6); par_write(1, 8'hFD); par_write(2, 8'h9C);
    src_primary = 1; check("R5 parallel strobe mapping");
    src_primary = 0; check("R4 secondary waits for hop");
    par_write(3, 8'h00); check("R4 hop copies in parallel");
    ser_bit(1'b1, 4); src_primary = 1;
    check("R1 serial clock ignored in parallel");
    par_write(4, 8'h60); check("R10 modulus select wins");
    par_write(4, 8'h47); check("R10 raw prescaler route");
    par_write(4, 8'h98); check("R7 parallel aux write");
    par_write(4, 8'h10); check("R9 immediate load flag");

    // direct mode
    pin_main = 7'h5A; pin_ref = 4'hE; pin_swl = 4'h3; pin_pre_en = 1;
    set_mode(1, 0); check("R8 direct pins");
    set_mode(1, 1); check("R1 direct overrides serial select");
    par_write(0, 8'h11); m_prim[15:8] = 8'hB6;
    set_mode(0, 0); src_primary = 1;
    check("R8 strobes ignored in direct");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom_range(0, 6));
      if (op <= 4) begin
        if (bus_serial) set_mode(0, 0);
        par_write(op, 8'($urandom));
      end else if (op == 5) begin
        set_mode(0, 1);
        ser_word(20'($urandom), 3);
        pulse(5, 3); m_sec = m_prim;
      end else begin
        src_primary = 1'($urandom);
        aux_en_n = 1'($urandom);
      end
      check("R5 R2 random mix");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule